// File: doc/BRIEF.md
# Machine Cycle Step Sequencer

This block produces the timing steps of a simple bus-oriented processor. A two-bit step counter runs on the master clock. A decoder turns the counter into one-hot step strobes, T1 to T4. In a bus transfer, T1 addresses the two devices, T2 opens the source's three-state driver, and T3 clocks the destination latch. The running instruction supplies a two-bit final-step index. The counter is compared with this index on every clock. When the final step is reached, the counter goes back to T1, so short cycles such as register-to-register moves take fewer clocks.

A synchronous bus WAIT line stretches memory traffic for slow memory-mapped peripherals. WAIT is sampled in T2 and T3 of a memory-read cycle and in T2 of a memory-write cycle. If WAIT is seen in any of these steps, the bus strobes stay low for the rest of the cycle. The cycle-end, IR-clear and PC-increment enables are also held back. The cycle then runs to its final step and starts again at T1, so the whole machine cycle repeats until WAIT drops. An interrupt taken during a stall needs no special handling, because the repeated cycle samples WAIT again.

Top module: `stepseq_top`

## Requirements
- R1: While `rstN` is low, at the next rising edge the step output becomes T1 (`stepHot` = 4'b0001) and all enables and `cycEnd` are low.
- R2: `stepHot` is one-hot. Bit i stands for step T(i+1). Outside the final step, each clock moves it to the next step.
- R3: `lastStep` is the index of the final step: 0 means T1, 1 means T2, 2 means T3 and 3 means T4. After the final step the next step is T1, so a cycle lasts `lastStep`+1 clocks, whether it was stalled or not.
- R4: `cycEnd` is high exactly in the final step of a cycle in which no sampled WAIT was seen.
- R5: With `cycKind` = 2'b01 (memory read), `rdEn` is high in T2 and T3 of steps that the cycle reaches, unless the cycle is stalled.
- R6: With `cycKind` = 2'b10 (memory write), `wrEn` is high in T2 only, unless the cycle is stalled. WAIT in T3 of a write has no effect.
- R7: If `waitIn` is high in a sampled step, `rdEn`/`wrEn` are low in that step and in every later step of the cycle. `cycEnd`, `irClrEn` and `pcIncEn` are not asserted in that cycle. WAIT in T1 or in T4 is not sampled.
- R8: `irClrEn` is high together with `cycEnd` when `execCycle` is 1, and at no other time.
- R9: `pcIncEn` is high together with `cycEnd` in a memory-read cycle with `execCycle` = 0, and at no other time.
- R10: With `cycKind` = 2'b00 or 2'b11 (internal), `rdEn` and `wrEn` stay low and `waitIn` has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Synchronous active-low reset |
| cycKind | input | 2 | Cycle type: 00 internal, 01 memory read, 10 memory write, 11 internal |
| lastStep | input | 2 | Index of the final step of the current cycle |
| execCycle | input | 1 | Current cycle is an execute cycle |
| waitIn | input | 1 | Synchronous bus WAIT from peripherals |
| stepHot | output | 4 | One-hot step strobes, bit 0 = T1 |
| rdEn | output | 1 | Qualified read (source open) enable |
| wrEn | output | 1 | Qualified write (latch clock) enable |
| cycEnd | output | 1 | Final step of a completed cycle |
| irClrEn | output | 1 | Instruction register clear enable |
| pcIncEn | output | 1 | Program counter increment enable |

## Verification
The hardest case to reach is a late stall. WAIT rises in T3 of a read after T2 has already read. The strobe must then stay low through the final step, the completion enables must be held back, and the next cycle must start cleanly at T1. The stimulus table sets a separate WAIT bit for each step of each cycle. It places WAIT only in T3, only in T2, only in an unsampled T1 or T4, or in T3 of a write. A stalled cycle is followed by the same cycle without WAIT, to show that the cycle repeats. A reset in the middle of a cycle is applied as a directed case.

// File: rtl/stepseq_pkg.sv
package stepseq_pkg;

  typedef enum logic [1:0] {
    CYC_INTERNAL = 2'b00,
    CYC_MEMRD    = 2'b01,
    CYC_MEMWR    = 2'b10,
    CYC_SPARE    = 2'b11
  } cycKindT;

  // strobes from control to the step datapath
  typedef struct packed {
    logic restart;   // return counter to T1
    logic advance;   // move to next step
    logic markHit;   // remember that WAIT spoiled this cycle
    logic clearHit;  // forget the stall mark at the cycle boundary
  } seqCmdT;

endpackage

// File: rtl/stepseq_track.sv
module stepseq_track
  import stepseq_pkg::*;
#(
  parameter int STEP_W = 2,
  localparam int NSTEPS = 1 << STEP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqCmdT            cmd,
  output logic [STEP_W-1:0] stepIdx,
  output logic [NSTEPS-1:0] stepHot,
  output logic              waitHit
);

  logic [STEP_W-1:0] cntQ;
  logic              hitQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cntQ <= '0;
    end else if (cmd.restart) begin
      cntQ <= '0;
    end else if (cmd.advance) begin
      cntQ <= cntQ + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      hitQ <= 1'b0;
    end else if (cmd.clearHit) begin
      hitQ <= 1'b0;
    end else if (cmd.markHit) begin
      hitQ <= 1'b1;
    end
  end

  // step decoder
  for (genvar i = 0; i < NSTEPS; i++) begin : g_dec
    assign stepHot[i] = (cntQ == STEP_W'(i));
  end

  assign stepIdx = cntQ;
  assign waitHit = hitQ;

endmodule

// File: rtl/stepseq_ctrl.sv
module stepseq_ctrl
  import stepseq_pkg::*;
#(
  parameter int STEP_W   = 2,
  parameter int RD_FIRST = 1,
  parameter int RD_LAST  = 2,
  parameter int WR_STEP  = 1
) (
  input  logic [STEP_W-1:0] stepIdx,
  input  logic [STEP_W-1:0] lastStep,
  input  cycKindT           kind,
  input  logic              execCycle,
  input  logic              waitIn,
  input  logic              waitHit,
  output seqCmdT            cmd,
  output logic              rdEn,
  output logic              wrEn,
  output logic              cycEnd,
  output logic              irClrEn,
  output logic              pcIncEn
);

  localparam logic [STEP_W-1:0] RdLo = RD_FIRST[STEP_W-1:0];
  localparam logic [STEP_W-1:0] RdHi = RD_LAST[STEP_W-1:0];
  localparam logic [STEP_W-1:0] WrAt = WR_STEP[STEP_W-1:0];

  logic isFinal;
  logic inRdWin;
  logic inWrWin;
  logic sampled;
  logic spoiled;

  always_comb begin
    isFinal = (stepIdx == lastStep);
    inRdWin = (kind == CYC_MEMRD) && (stepIdx >= RdLo) && (stepIdx <= RdHi);
    inWrWin = (kind == CYC_MEMWR) && (stepIdx == WrAt);
    sampled = inRdWin || inWrWin;
    spoiled = waitHit || (sampled && waitIn);

    rdEn    = inRdWin && !spoiled;
    wrEn    = inWrWin && !spoiled;
    cycEnd  = isFinal && !spoiled;
    irClrEn = cycEnd && execCycle;
    pcIncEn = cycEnd && (kind == CYC_MEMRD) && !execCycle;

    cmd.restart  = isFinal;
    cmd.advance  = !isFinal;
    cmd.markHit  = sampled && waitIn && !isFinal;
    cmd.clearHit = isFinal;
  end

endmodule

// File: rtl/stepseq_top.sv
module stepseq_top
  import stepseq_pkg::*;
#(
  parameter int STEP_W = 2,
  localparam int NSTEPS = 1 << STEP_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [1:0]        cycKind,
  input  logic [STEP_W-1:0] lastStep,
  input  logic              execCycle,
  input  logic              waitIn,
  output logic [NSTEPS-1:0] stepHot,
  output logic              rdEn,
  output logic              wrEn,
  output logic              cycEnd,
  output logic              irClrEn,
  output logic              pcIncEn
);

  seqCmdT            cmd;
  logic [STEP_W-1:0] stepIdx;
  logic              waitHit;
  logic              rdRaw;
  logic              wrRaw;
  logic              endRaw;
  logic              irRaw;
  logic              pcRaw;

  stepseq_track #(.STEP_W(STEP_W)) u_track (
    .clk     (clk),
    .rstN    (rstN),
    .cmd     (cmd),
    .stepIdx (stepIdx),
    .stepHot (stepHot),
    .waitHit (waitHit)
  );

  stepseq_ctrl #(.STEP_W(STEP_W)) u_ctrl (
    .stepIdx   (stepIdx),
    .lastStep  (lastStep),
    .kind      (cycKindT'(cycKind)),
    .execCycle (execCycle),
    .waitIn    (waitIn),
    .waitHit   (waitHit),
    .cmd       (cmd),
    .rdEn      (rdRaw),
    .wrEn      (wrRaw),
    .cycEnd    (endRaw),
    .irClrEn   (irRaw),
    .pcIncEn   (pcRaw)
  );

  // enables are forced low while reset is held
  assign rdEn    = rdRaw  && rstN;
  assign wrEn    = wrRaw  && rstN;
  assign cycEnd  = endRaw && rstN;
  assign irClrEn = irRaw  && rstN;
  assign pcIncEn = pcRaw  && rstN;

endmodule

// File: rtl/stepseq_checker.sv
module stepseq_checker #(
  parameter int STEP_W = 2,
  localparam int NSTEPS = 1 << STEP_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [1:0]        cycKind,
  input logic [STEP_W-1:0] lastStep,
  input logic              execCycle,
  input logic              waitIn,
  input logic [NSTEPS-1:0] stepHot,
  input logic              rdEn,
  input logic              wrEn,
  input logic              cycEnd,
  input logic              irClrEn,
  input logic              pcIncEn
);

  AST_STEP_ONEHOT: assert property (@(posedge clk) disable iff (!rstN) $onehot(stepHot)); // R2
  AST_STEP_ADVANCE: assert property (@(posedge clk) disable iff (!rstN)
    !stepHot[lastStep] |=> stepHot == {$past(stepHot[NSTEPS-2:0]), $past(stepHot[NSTEPS-1])}); // R2
  AST_RESTART_T1: assert property (@(posedge clk) disable iff (!rstN)
    stepHot[lastStep] |=> stepHot[0]); // R3
  AST_END_ON_FINAL: assert property (@(posedge clk) disable iff (!rstN)
    cycEnd |-> stepHot[lastStep]); // R4
  AST_RD_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> (cycKind == 2'b01) && (stepHot[1] || stepHot[2])); // R5
  AST_WR_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> (cycKind == 2'b10) && stepHot[1]); // R6
  AST_WAIT_BLOCKS_RD: assert property (@(posedge clk) disable iff (!rstN)
    rdEn |-> !waitIn); // R7
  AST_WAIT_BLOCKS_WR: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |-> !waitIn); // R7
  AST_IRCLR_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    irClrEn |-> cycEnd && execCycle); // R8
  AST_PCINC_AT_END: assert property (@(posedge clk) disable iff (!rstN)
    pcIncEn |-> cycEnd && !execCycle && (cycKind == 2'b01)); // R9
  AST_INTERNAL_NO_BUS: assert property (@(posedge clk) disable iff (!rstN)
    (cycKind == 2'b00 || cycKind == 2'b11) |-> !rdEn && !wrEn); // R10

endmodule

bind stepseq_top stepseq_checker #(.STEP_W(STEP_W)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .cycKind   (cycKind),
  .lastStep  (lastStep),
  .execCycle (execCycle),
  .waitIn    (waitIn),
  .stepHot   (stepHot),
  .rdEn      (rdEn),
  .wrEn      (wrEn),
  .cycEnd    (cycEnd),
  .irClrEn   (irClrEn),
  .pcIncEn   (pcIncEn)
);

// File: tb/stepseq_top_bench.sv
`timescale 1ns/1ps
module stepseq_top_bench;

  logic       clk = 1'b0;
  logic       rstN;
  logic [1:0] cycKind;
  logic [1:0] lastStep;
  logic       execCycle;
  logic       waitIn;
  logic [3:0] stepHot;
  logic       rdEn, wrEn, cycEnd, irClrEn, pcIncEn;

  int checkCnt = 0;
  int failCnt  = 0;

  always #10 clk = ~clk;

  stepseq_top u_stepseq_top (
    .clk(clk), .rstN(rstN), .cycKind(cycKind), .lastStep(lastStep),
    .execCycle(execCycle), .waitIn(waitIn), .stepHot(stepHot),
    .rdEn(rdEn), .wrEn(wrEn), .cycEnd(cycEnd), .irClrEn(irClrEn), .pcIncEn(pcIncEn)
  );

  // {kind, last, exec, wait per step, expected rd per step, expected wr per step, completes}
  localparam int NVEC = 14;
  localparam logic [17:0] VEC [NVEC] = '{
    {2'd1, 2'd2, 1'b0, 4'b0000, 4'b0110, 4'b0000, 1'b1}, // read, plain
    {2'd1, 2'd2, 1'b0, 4'b0010, 4'b0000, 4'b0000, 1'b0}, // read, WAIT in T2
    {2'd1, 2'd2, 1'b0, 4'b0100, 4'b0010, 4'b0000, 1'b0}, // read, WAIT only in T3
    {2'd1, 2'd2, 1'b0, 4'b0000, 4'b0110, 4'b0000, 1'b1}, // repeat completes
    {2'd1, 2'd2, 1'b0, 4'b0001, 4'b0110, 4'b0000, 1'b1}, // WAIT in T1 not sampled
    {2'd2, 2'd2, 1'b1, 4'b0000, 4'b0000, 4'b0010, 1'b1}, // write exec
    {2'd2, 2'd2, 1'b1, 4'b0010, 4'b0000, 4'b0000, 1'b0}, // write, WAIT in T2
    {2'd2, 2'd2, 1'b0, 4'b0100, 4'b0000, 4'b0010, 1'b1}, // write, WAIT in T3 ignored
    {2'd0, 2'd1, 1'b1, 4'b1111, 4'b0000, 4'b0000, 1'b1}, // reg-to-reg, two steps
    {2'd0, 2'd0, 1'b1, 4'b0000, 4'b0000, 4'b0000, 1'b1}, // single step
    {2'd0, 2'd3, 1'b0, 4'b0000, 4'b0000, 4'b0000, 1'b1}, // four steps
    {2'd1, 2'd3, 1'b1, 4'b1000, 4'b0110, 4'b0000, 1'b1}, // WAIT in T4 not sampled
    {2'd1, 2'd1, 1'b0, 4'b0000, 4'b0010, 4'b0000, 1'b1}, // short read
    {2'd3, 2'd2, 1'b0, 4'b1111, 4'b0000, 4'b0000, 1'b1}  // spare kind is internal
  };

  task automatic check(input string req, input int act, input int exp);
    checkCnt++;
    if (act != exp) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checkCnt - failCnt, checkCnt);
    $finish;
  endtask

  // runs one machine cycle; caller is at a negedge at T1
  task automatic runCycle(input logic [17:0] v);
    logic [1:0] k;
    logic [1:0] l;
    logic       ex;
    k  = v[17:16];
    l  = v[15:14];
    ex = v[13];
    for (int s = 0; s <= int'(l); s++) begin
      cycKind   = k;
      lastStep  = l;
      execCycle = ex;
      waitIn    = v[9 + s];
      #1;
      check("R2 step", int'(stepHot), 1 << s);
      check(v[12:9] != 0 ? "R7 rdEn" : "R5 rdEn", int'(rdEn), int'(v[5 + s]));
      check(v[12:9] != 0 ? "R7 wrEn" : "R6 wrEn", int'(wrEn), int'(v[1 + s]));
      if (k == 2'd0 || k == 2'd3) check("R10 no bus", int'(rdEn | wrEn), 0);
      check("R4 cycEnd", int'(cycEnd), int'(s == int'(l) && v[0]));
      check("R8 irClrEn", int'(irClrEn), int'(s == int'(l) && v[0] && ex));
      check("R9 pcIncEn", int'(pcIncEn), int'(s == int'(l) && v[0] && k == 2'd1 && !ex));
      @(negedge clk);
    end
    #1;
    check("R3 back to T1", int'(stepHot), 1);
  endtask

  initial begin
    rstN = 1'b0; cycKind = 2'd1; lastStep = 2'd2; execCycle = 1'b0; waitIn = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    check("R1 reset step", int'(stepHot), 1);
    check("R1 reset enables", int'({rdEn, wrEn, cycEnd, irClrEn, pcIncEn}), 0);
    rstN = 1'b1;
    for (int i = 0; i < NVEC; i++) runCycle(VEC[i]);

    // reset in the middle of a read cycle
    cycKind = 2'd1; lastStep = 2'd3; waitIn = 1'b0; execCycle = 1'b0;
    @(negedge clk);
    @(negedge clk);
    #1;
    check("R2 pre-reset T3", int'(stepHot), 4);
    rstN = 1'b0;
    @(negedge clk);
    #1;
    check("R1 mid reset step", int'(stepHot), 1);
    check("R1 mid reset enables", int'({rdEn, wrEn, cycEnd, irClrEn, pcIncEn}), 0);
    rstN = 1'b1;
    runCycle(VEC[0]);
    summary();
  end

  initial begin
    #4_000_000;
    checkCnt++;
    failCnt++;
    $display("FAIL watchdog R2 actual=hung expected=done");
    summary();
  end

endmodule